// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Word Interrupt Qualification

This block receives asynchronous serial frames on a single line, oversampling each bit period with a baud tick that runs at sixteen times the bit rate. A frame is one low start bit, then eight or nine data bits sent least significant bit first, then one high stop bit. When a frame completes, the assembled word is held at the output and a sticky ready flag is raised. The flag stays set until the host pulses an acknowledge.

The receive interrupt request is derived from the ready flag. With address qualification switched on, only words whose top bit is set raise the request. On a multi-drop bus this means the host is disturbed only by address words and never by data meant for other nodes. The top bit is always reported as an address indication.

Parity checking shares the top bit, so it only applies while address qualification is off. Clearing the module enable or the receiver enable at any time aborts a frame in progress, and no word is delivered for it.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_word is 0 and data_ready, rx_irq, is_addr, frame_err and parity_err are all 0.
- R2: A frame is received as a low start bit, then N data bits least significant first, then a stop bit, with 16 baud ticks per bit and sampling at mid-bit. N is 9 when word9=1 and 8 when word9=0. In 8-bit mode the word appears on rx_word[7:0] and rx_word[8] is 0.
- R3: When addr_det_en=1, rx_irq is raised for a completed word only if its top bit is 1. The top bit is rx_word[8] in 9-bit mode and rx_word[7] in 8-bit mode.
- R4: is_addr equals the top bit of the delivered word, whatever the value of addr_det_en.
- R5: When addr_det_en=0, every completed word raises rx_irq, whatever its top bit.
- R6: When parity_en=1 and addr_det_en=0, parity_err is 1 exactly when the delivered word (top bit included) has an odd number of ones. When addr_det_en=1, parity_err is 0.
- R7: A low pulse on rxd that has ended before the mid-point of the start bit is discarded, and no word is delivered for it.
- R8: If the stop-bit sample is low, frame_err is set and the word is still delivered with data_ready raised.
- R9: Dropping mod_en or rx_en during a frame aborts it, and data_ready is not raised for that frame.
- R10: data_ready and rx_irq stay set until a one-cycle rd_ack pulse, which clears both.
- R11: rx_irq is never 1 while data_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addr_det_en | input | 1 | Interrupt only on words whose top bit is set |
| parity_en | input | 1 | Enables the even-parity check over the word |
| rx_en | input | 1 | Receiver enable |
| mod_en | input | 1 | Module enable |
| rd_ack | input | 1 | Read acknowledge; clears data_ready and rx_irq |
| rx_word | output | 9 | Last received word |
| data_ready | output | 1 | Sticky word-available flag |
| rx_irq | output | 1 | Qualified receive interrupt request |
| is_addr | output | 1 | Top bit of the last word |
| frame_err | output | 1 | Stop-bit sample was low |
| parity_err | output | 1 | Odd number of ones with parity enabled |

## Verification
The main function is driven with words in both lengths whose top bit is set and whose top bit is clear, once with address qualification on and once with it off. This separates the interrupt gating from the address indication, and it shows that the correct bit position is used as the top bit in each mode. Words with odd and with even numbers of ones, sent with parity enabled, show that the parity check follows the count of ones and is forced off while address qualification is active. Directed frames then cover a short glitch on the line, a disable in the middle of a frame, a low stop bit, and the stickiness of the ready flag until acknowledge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  // The line idles high, so the chain resets to ones and no false start is seen.
  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                word9_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] word_o,
  output logic                w9_o,
  output logic                stop_ok_o
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(MAX_BITS + 1);
  localparam int HALF = OVS / 2 - 1;

  rx_state_t           state;
  logic [CW-1:0]       tcnt;
  logic [BW-1:0]       bcnt;
  logic [MAX_BITS-1:0] sh;
  logic                w9_q;
  logic [BW-1:0]       last_bit;

  assign last_bit = w9_q ? BW'(MAX_BITS - 1) : BW'(MAX_BITS - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      sh        <= '0;
      w9_q      <= 1'b0;
      done_o    <= 1'b0;
      word_o    <= '0;
      w9_o      <= 1'b0;
      stop_ok_o <= 1'b1;
    end else if (!en_i) begin
      state  <= RX_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state)
          RX_IDLE: begin
            if (!rx_i) begin
              state <= RX_START;
              tcnt  <= '0;
              w9_q  <= word9_i;
            end
          end
          RX_START: begin
            if (tcnt == CW'(HALF)) begin
              tcnt  <= '0;
              bcnt  <= '0;
              state <= rx_i ? RX_IDLE : RX_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt == CW'(OVS - 1)) begin
              tcnt <= '0;
              sh   <= {rx_i, sh[MAX_BITS-1:1]};
              if (bcnt == last_bit) state <= RX_STOP;
              else                  bcnt  <= bcnt + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (tcnt == CW'(OVS - 1)) begin
              tcnt      <= '0;
              state     <= RX_IDLE;
              done_o    <= 1'b1;
              stop_ok_o <= rx_i;
              w9_o      <= w9_q;
              word_o    <= w9_q ? sh : {1'b0, sh[MAX_BITS-1:1]};
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R9: a disable forces the frame engine back to idle on the next cycle
  a_r9_disable_to_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (state == RX_IDLE && !done_o));

  // R2: a word is only delivered straight out of the stop-bit phase
  a_r2_done_after_stop: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(state == RX_STOP));
endmodule

// File: rtl/rx_irq_qual.sv
module rx_irq_qual #(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done_i,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic                w9_i,
  input  logic                stop_ok_i,
  input  logic                addr_en_i,
  input  logic                par_en_i,
  input  logic                ack_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic                ready_o,
  output logic                irq_o,
  output logic                is_addr_o,
  output logic                frame_err_o,
  output logic                parity_err_o
);
  logic top_bit;

  assign top_bit = w9_i ? word_i[MAX_BITS-1] : word_i[MAX_BITS-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o       <= '0;
      ready_o      <= 1'b0;
      irq_o        <= 1'b0;
      is_addr_o    <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
    end else if (done_i) begin
      word_o       <= word_i;
      ready_o      <= 1'b1;
      irq_o        <= !addr_en_i || top_bit;
      is_addr_o    <= top_bit;
      frame_err_o  <= !stop_ok_i;
      parity_err_o <= par_en_i && !addr_en_i && (^word_i);
    end else if (ack_i) begin
      ready_o <= 1'b0;
      irq_o   <= 1'b0;
    end
  end

  // R11: the request never stands without the ready flag
  a_r11_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ready_o);

  // R3: a data word does not interrupt while qualification is on
  a_r3_data_word_quiet: assert property (@(posedge clk) disable iff (rst)
    (done_i && addr_en_i && !top_bit) |=> !irq_o);

  // R5: with qualification off every word interrupts
  a_r5_every_word_irq: assert property (@(posedge clk) disable iff (rst)
    (done_i && !addr_en_i) |=> (irq_o && ready_o));

  // R6: parity is not reported while address qualification is on
  a_r6_parity_off_in_addr: assert property (@(posedge clk) disable iff (rst)
    (done_i && addr_en_i) |=> !parity_err_o);

  // R10: acknowledge clears ready and request
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !done_i) |=> (!ready_o && !irq_o));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OVS         = 16,
  parameter int WORD_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic                rxd,
  input  logic                word9,
  input  logic                addr_det_en,
  input  logic                parity_en,
  input  logic                rx_en,
  input  logic                mod_en,
  input  logic                rd_ack,
  output logic [WORD_MAX-1:0] rx_word,
  output logic                data_ready,
  output logic                rx_irq,
  output logic                is_addr,
  output logic                frame_err,
  output logic                parity_err
);
  logic                rx_s;
  logic                run;
  logic                fe_done;
  logic [WORD_MAX-1:0] fe_word;
  logic                fe_w9;
  logic                fe_stop_ok;

  assign run = mod_en && rx_en;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rxd),
    .q_o (rx_s)
  );

  rx_frame_engine #(.OVS(OVS), .MAX_BITS(WORD_MAX)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .en_i      (run),
    .tick_i    (baud_tick),
    .rx_i      (rx_s),
    .word9_i   (word9),
    .done_o    (fe_done),
    .word_o    (fe_word),
    .w9_o      (fe_w9),
    .stop_ok_o (fe_stop_ok)
  );

  rx_irq_qual #(.MAX_BITS(WORD_MAX)) u_qual (
    .clk          (clk),
    .rst          (rst),
    .done_i       (fe_done),
    .word_i       (fe_word),
    .w9_i         (fe_w9),
    .stop_ok_i    (fe_stop_ok),
    .addr_en_i    (addr_det_en),
    .par_en_i     (parity_en),
    .ack_i        (rd_ack),
    .word_o       (rx_word),
    .ready_o      (data_ready),
    .irq_o        (rx_irq),
    .is_addr_o    (is_addr),
    .frame_err_o  (frame_err),
    .parity_err_o (parity_err)
  );

  // R9: no word is delivered while the receiver is disabled
  a_r9_no_ready_rise_disabled: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(data_ready)) |-> !data_ready);
endmodule

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;
  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick;
  logic [1:0] tdiv = 2'd0;
  logic       rxd = 1'b1;
  logic       word9 = 1'b0, addr_det_en = 1'b0, parity_en = 1'b0;
  logic       rx_en = 1'b1, mod_en = 1'b1, rd_ack = 1'b0;
  logic [8:0] rx_word;
  logic       data_ready, rx_irq, is_addr, frame_err, parity_err;

  int nchecks = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  uart_addr_rx u_uart_addr_rx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
    .word9(word9), .addr_det_en(addr_det_en), .parity_en(parity_en),
    .rx_en(rx_en), .mod_en(mod_en), .rd_ack(rd_ack),
    .rx_word(rx_word), .data_ready(data_ready), .rx_irq(rx_irq),
    .is_addr(is_addr), .frame_err(frame_err), .parity_err(parity_err)
  );

  // {w9, aden, pen, word[8:0], stop, exp_irq, exp_addr, exp_perr, exp_ferr}
  localparam logic [16:0] VEC [0:10] = '{
    {1'b0,1'b0,1'b0,9'h0A5,1'b1, 1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b1,1'b0,9'h03C,1'b1, 1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,9'h081,1'b1, 1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b1,1'b0,9'h155,1'b1, 1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b1,1'b0,9'h0FF,1'b1, 1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,9'h0FF,1'b1, 1'b1,1'b0,1'b0,1'b0},
    {1'b0,1'b0,1'b1,9'h007,1'b1, 1'b1,1'b0,1'b1,1'b0},
    {1'b1,1'b0,1'b1,9'h103,1'b1, 1'b1,1'b1,1'b1,1'b0},
    {1'b0,1'b1,1'b1,9'h0F1,1'b1, 1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b0,1'b1,9'h033,1'b1, 1'b1,1'b0,1'b0,1'b0},
    {1'b0,1'b0,1'b0,9'h055,1'b0, 1'b1,1'b0,1'b0,1'b1}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic w9, input logic [8:0] w, input logic stop);
    rxd = 1'b0; clks(BITCLK);
    for (int i = 0; i < (w9 ? 9 : 8); i++) begin
      rxd = w[i]; clks(BITCLK);
    end
    rxd = stop; clks(BITCLK);
    rxd = 1'b1; clks(8);
  endtask

  task automatic ack();
    rd_ack = 1'b1; clks(1);
    rd_ack = 1'b0; clks(1);
  endtask

  initial begin
    clks(4);
    rst = 1'b0; clks(2);
    // R1 reset state
    check("R1 rx_word", rx_word, 9'h000);
    check("R1 flags", {4'b0, data_ready, rx_irq, is_addr, frame_err, parity_err}, 9'h000);

    for (int v = 0; v < 11; v++) begin
      logic [16:0] e;
      logic [8:0]  xw;
      e = VEC[v];
      word9 = e[16]; addr_det_en = e[15]; parity_en = e[14];
      send_frame(e[16], e[13:5], e[4]);
      xw = e[16] ? e[13:5] : {1'b0, e[12:5]};
      check("R2 word", rx_word, xw);
      check(e[4] ? "R2 ready" : "R8 ready on bad stop", {8'b0, data_ready}, 9'h001);
      check(e[15] ? "R3 irq" : "R5 irq", {8'b0, rx_irq}, {8'b0, e[3]});
      check("R4 is_addr", {8'b0, is_addr}, {8'b0, e[2]});
      check("R6 parity_err", {8'b0, parity_err}, {8'b0, e[1]});
      check("R8 frame_err", {8'b0, frame_err}, {8'b0, e[0]});
      ack();
      check("R10 ack clears", {7'b0, data_ready, rx_irq}, 9'h000);
      check("R11 irq without ready", {8'b0, rx_irq && !data_ready}, 9'h000);
    end

    // Directed tests start from a fresh reset
    addr_det_en = 1'b0; parity_en = 1'b0; word9 = 1'b0; rxd = 1'b1;
    rst = 1'b1; clks(BITCLK);
    rst = 1'b0; clks(2);
    check("R1 after reset", {3'b0, rx_word[5:0]}, 9'h000);
    check("R1 ready after reset", {8'b0, data_ready}, 9'h000);

    // R7 glitch shorter than half a bit
    rxd = 1'b0; clks(12);
    rxd = 1'b1; clks(12 * BITCLK);
    check("R7 glitch ignored", {8'b0, data_ready}, 9'h000);

    // R9 disable in the middle of a frame
    rxd = 1'b0; clks(BITCLK);
    rxd = 1'b1; clks(BITCLK);
    rxd = 1'b0; clks(2 * BITCLK);
    mod_en = 1'b0; clks(8);
    mod_en = 1'b1; rxd = 1'b1; clks(12 * BITCLK);
    check("R9 mod_en abort", {8'b0, data_ready}, 9'h000);
    rxd = 1'b0; clks(3 * BITCLK);
    rx_en = 1'b0; clks(8);
    rx_en = 1'b1; rxd = 1'b1; clks(12 * BITCLK);
    check("R9 rx_en abort", {8'b0, data_ready}, 9'h000);

    // R10 ready and request are sticky until acknowledge
    send_frame(1'b0, 9'h05A, 1'b1);
    clks(400);
    check("R10 ready sticky", {8'b0, data_ready}, 9'h001);
    check("R10 irq sticky", {8'b0, rx_irq}, 9'h001);
    check("R2 recovered word", rx_word, 9'h05A);
    ack();
    check("R10 cleared", {7'b0, data_ready, rx_irq}, 9'h000);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule